// File: doc/BRIEF.md
# Aliased General-Purpose Register File

This block holds the eight 32-bit general-purpose registers of a processor core and lets the core reach each register through narrower views. Every register can be read or written whole (dword) or through its lower 16 bits (word). The first four registers also offer two byte views inside that lower half: the low byte and the high byte.

A narrow write merges into the shared 32-bit register and leaves every bit outside its own field unchanged. A narrow read returns the selected field right-aligned and zero-extended to 32 bits. The file has one write port and two independent read ports. Each port carries a register index and a view selector.

Reads are combinational from the stored state, so a read of the register being written in the same cycle returns the old contents. A high-byte view on registers 4 to 7 is illegal. Such a request raises that port's error output, a read of that kind returns zero, and a write of that kind is dropped.

Top module: `gpr_alias_file`

## Requirements
- R1: A synchronous active-low reset clears all eight registers to zero. After reset, every view of every register reads zero.
- R2: A dword write (view code 2'b00) replaces all 32 bits of register `wr_idx` with `wr_data`. The new value is readable in the cycle after the clock edge, and no other register changes.
- R3: A word write (view code 2'b01) copies `wr_data[15:0]` into bits 15:0 of the register and keeps bits 31:16.
- R4: A low-byte write (view code 2'b10) copies `wr_data[7:0]` into bits 7:0 and keeps all other bits.
- R5: A high-byte write (view code 2'b11) to registers 0 to 3 copies `wr_data[7:0]` into bits 15:8 and keeps all other bits.
- R6: Reads are zero-extended to 32 bits. A word view returns `{16'h0, r[15:0]}`, a low-byte view returns `{24'h0, r[7:0]}`, a high-byte view returns `{24'h0, r[15:8]}`, and a dword view returns `r`.
- R7: A high-byte view on index 4 to 7 is illegal. It raises `wr_err` (only when `wr_en` is high) or that read port's `rdN_err` in the same cycle. The write is suppressed and the read data is zero. A legal view keeps the error output low.
- R8: A read of the register being written in the same cycle returns its value from before the write.
- R9: The two read ports are independent: each returns its own index and view in the same cycle.
- R10: With `wr_en` low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Register index to write |
| wr_view | input | 2 | View of the write: 00 dword, 01 word, 10 low byte, 11 high byte |
| wr_data | input | 32 | Write value, right-aligned for narrow views |
| wr_err | output | 1 | Illegal write view requested |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_view | input | 2 | Read port 0 view |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 illegal view |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_view | input | 2 | Read port 1 view |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 illegal view |

## Verification
The merge logic is tested with a chain of writes of every view width into one register, each followed by a dword readback. This shows that only the addressed bytes move, and a lane-enable or data-alignment error shows up as a wrong byte position. Byte-distinct values are read back through narrower views, so a shift or zero-extension fault cannot mask itself. Directed cases set an illegal high-byte view on an upper register against a legal one, a same-cycle read of the written register against the following cycle, both read ports at once on different registers and views, a held write strobe, and a reset issued mid-run.

// File: rtl/gpr_pkg.sv
// Shared definitions for the aliased register file.
// Assumes the view code is two bits wide and fixed, since the core decodes it.
package gpr_pkg;

    typedef enum logic [1:0] {
        VIEW_DWORD = 2'b00,
        VIEW_WORD  = 2'b01,
        VIEW_LOW   = 2'b10,
        VIEW_HIGH  = 2'b11
    } view_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/gpr_view_decode.sv
// Turns a register index and view code into byte-lane enables, the bit offset
// of the field and a legality flag.
// Assumes DATA_W is a multiple of 8 and at least 16. Byte views exist only
// below BYTE_VIEW_REGS. An illegal view yields no lanes at all.
module gpr_view_decode
    import gpr_pkg::*;
#(
    parameter int NUM_REGS       = 8,
    parameter int DATA_W         = 32,
    parameter int BYTE_VIEW_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int LANES   = DATA_W / BYTE_W,
    localparam int SHIFT_W = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]   idx,
    input  view_e              view,
    output logic [LANES-1:0]   lane_mask,
    output logic [SHIFT_W-1:0] shift,
    output logic               legal
);

    // Select the lanes and the field offset for the requested view.
    always_comb begin
        lane_mask = '0;
        shift     = '0;
        legal     = 1'b1;
        case (view)
            VIEW_DWORD: lane_mask = '1;
            VIEW_WORD:  lane_mask = LANES'(2'b11);
            VIEW_LOW:   lane_mask = LANES'(2'b01);
            VIEW_HIGH: begin
                lane_mask = LANES'(2'b10);
                shift     = SHIFT_W'(BYTE_W);
                legal     = (int'(idx) < BYTE_VIEW_REGS);
            end
            default:    lane_mask = '0;
        endcase
        if (!legal) begin
            lane_mask = '0;
        end
    end

endmodule

// File: rtl/gpr_lane_bank.sv
// Storage for the general-purpose registers, written one byte lane at a time.
// Assumes the write data arrives already shifted into lane position and the
// lane mask comes from a view decoder. The whole array is visible for
// combinational reads, so the old value is seen until the clock edge.
module gpr_lane_bank
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int LANES   = DATA_W / BYTE_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [LANES-1:0]                   wr_lanes,
    input  logic [DATA_W-1:0]                  wr_aligned,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_q
);

    logic [NUM_REGS-1:0][LANES-1:0] lane_we;

    // Combine the strobe, the register select and the lane mask per byte.
    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            lane_we[r] = (wr_en && (int'(wr_idx) == r)) ? wr_lanes : '0;
        end
    end

    // Clear on reset, otherwise update only the enabled bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_we[r][l]) begin
                        regs_q[r][l*BYTE_W +: BYTE_W] <= wr_aligned[l*BYTE_W +: BYTE_W];
                    end
                end
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (regs_q == '0)) else $error("registers not clear after reset"); // R1

    for (genvar gr = 0; gr < NUM_REGS; gr++) begin : g_reg_chk
        for (genvar gl = 0; gl < LANES; gl++) begin : g_lane_chk
            AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !lane_we[gr][gl] |=> $stable(regs_q[gr][gl*BYTE_W +: BYTE_W]))
                else $error("byte lane changed without enable"); // R10
        end
    end

endmodule

// File: rtl/gpr_read_port.sv
// One read port: selects a register and extracts the requested view,
// right-aligned and zero-extended.
// Assumes the register array comes straight from storage, so the data follows
// the stored state with no bypass. An illegal view returns zero and raises err.
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int NUM_REGS       = 8,
    parameter int DATA_W         = 32,
    parameter int BYTE_VIEW_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int LANES   = DATA_W / BYTE_W,
    localparam int SHIFT_W = $clog2(DATA_W)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [IDX_W-1:0]                rd_idx,
    input  logic [1:0]                      rd_view,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            rd_err
);

    logic [LANES-1:0]   lane_mask;
    logic [SHIFT_W-1:0] shift;
    logic               legal;
    logic [DATA_W-1:0]  bit_mask;

    gpr_view_decode #(
        .NUM_REGS       (NUM_REGS),
        .DATA_W         (DATA_W),
        .BYTE_VIEW_REGS (BYTE_VIEW_REGS)
    ) u_dec (
        .idx       (rd_idx),
        .view      (view_e'(rd_view)),
        .lane_mask (lane_mask),
        .shift     (shift),
        .legal     (legal)
    );

    // Widen the lane mask to bits, then mask and right-align the field.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            bit_mask[l*BYTE_W +: BYTE_W] = {BYTE_W{lane_mask[l]}};
        end
        rd_data = (regs[rd_idx] & bit_mask) >> shift;
        rd_err  = !legal;
    end

    AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_view != 2'b00) |-> (rd_data[DATA_W-1:16] == '0)) else $error("word view not zero-extended"); // R6
    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_view[1] |-> (rd_data[DATA_W-1:BYTE_W] == '0)) else $error("byte view not zero-extended"); // R6
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == '0)) else $error("illegal read returned data"); // R7

endmodule

// File: rtl/gpr_alias_file.sv
// Register file with aliased narrow views: one write port, two read ports.
// Assumes views are coded 00 dword, 01 word, 10 low byte, 11 high byte, and
// that the high byte exists only on the first BYTE_VIEW_REGS registers.
// Narrow writes merge into the full register. Reads see the pre-write value.
module gpr_alias_file
    import gpr_pkg::*;
#(
    parameter int NUM_REGS       = 8,
    parameter int DATA_W         = 32,
    parameter int BYTE_VIEW_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int LANES   = DATA_W / BYTE_W,
    localparam int SHIFT_W = $clog2(DATA_W),
    localparam int NUM_RD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_view,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_view,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_err,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_view,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_err
);

    logic [LANES-1:0]               wr_lanes;
    logic [SHIFT_W-1:0]             wr_shift;
    logic                           wr_legal;
    logic [DATA_W-1:0]              wr_aligned;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx_a;
    logic [NUM_RD-1:0][1:0]         rd_view_a;
    logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_a;
    logic [NUM_RD-1:0]              rd_err_a;

    gpr_view_decode #(
        .NUM_REGS       (NUM_REGS),
        .DATA_W         (DATA_W),
        .BYTE_VIEW_REGS (BYTE_VIEW_REGS)
    ) u_wr_dec (
        .idx       (wr_idx),
        .view      (view_e'(wr_view)),
        .lane_mask (wr_lanes),
        .shift     (wr_shift),
        .legal     (wr_legal)
    );

    // Move right-aligned write data into lane position and flag illegal writes.
    always_comb begin
        wr_aligned = wr_data << wr_shift;
        wr_err     = wr_en && !wr_legal;
    end

    gpr_lane_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_lanes   (wr_lanes),
        .wr_aligned (wr_aligned),
        .regs_q     (regs_q)
    );

    // Gather the read port pins into arrays for the replicated port logic.
    always_comb begin
        rd_idx_a[0]  = rd0_idx;
        rd_view_a[0] = rd0_view;
        rd_idx_a[1]  = rd1_idx;
        rd_view_a[1] = rd1_view;
        rd0_data     = rd_data_a[0];
        rd0_err      = rd_err_a[0];
        rd1_data     = rd_data_a[1];
        rd1_err      = rd_err_a[1];
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gpr_read_port #(
            .NUM_REGS       (NUM_REGS),
            .DATA_W         (DATA_W),
            .BYTE_VIEW_REGS (BYTE_VIEW_REGS)
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .regs    (regs_q),
            .rd_idx  (rd_idx_a[p]),
            .rd_view (rd_view_a[p]),
            .rd_data (rd_data_a[p]),
            .rd_err  (rd_err_a[p])
        );
    end

    AST_DWORD_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'b00) |=> (regs_q[$past(wr_idx)] == $past(wr_data)))
        else $error("dword write not stored"); // R2
    AST_BAD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> (regs_q == $past(regs_q))) else $error("illegal write changed state"); // R7
    AST_LOW_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'b10) |=>
        (regs_q[$past(wr_idx)][DATA_W-1:BYTE_W] == $past(regs_q[wr_idx][DATA_W-1:BYTE_W])))
        else $error("low byte write touched upper bits"); // R4

endmodule

// File: tb/gpr_alias_file_tb.sv
`timescale 1ns/1ps
module gpr_alias_file_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_view = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic [2:0]  rd0_idx = '0;
    logic [1:0]  rd0_view = '0;
    logic [31:0] rd0_data;
    logic        rd0_err;
    logic [2:0]  rd1_idx = '0;
    logic [1:0]  rd1_view = '0;
    logic [31:0] rd1_data;
    logic        rd1_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpr_alias_file u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    // Views: 0 dword, 1 word, 2 low byte, 3 high byte.
    // Entry: {req, wr_idx, wr_view, wr_data, rd_idx, rd_view, expected}
    localparam int NV = 12;
    localparam logic [77:0] VEC [NV] = '{
        {4'd2, 3'd0, 2'd0, 32'h11223344, 3'd0, 2'd0, 32'h11223344}, // R2
        {4'd3, 3'd0, 2'd1, 32'hAAAA5566, 3'd0, 2'd0, 32'h11225566}, // R3
        {4'd4, 3'd0, 2'd2, 32'hFFFFFF77, 3'd0, 2'd0, 32'h11225577}, // R4
        {4'd5, 3'd0, 2'd3, 32'h000000C3, 3'd0, 2'd0, 32'h1122C377}, // R5
        {4'd6, 3'd1, 2'd0, 32'hDEADBEEF, 3'd1, 2'd3, 32'h000000BE}, // R6
        {4'd5, 3'd1, 2'd3, 32'h00000012, 3'd1, 2'd1, 32'h000012EF}, // R5
        {4'd4, 3'd1, 2'd2, 32'h00000034, 3'd1, 2'd2, 32'h00000034}, // R4
        {4'd6, 3'd5, 2'd0, 32'hCAFEF00D, 3'd5, 2'd1, 32'h0000F00D}, // R6
        {4'd4, 3'd5, 2'd2, 32'h00000099, 3'd5, 2'd0, 32'hCAFEF099}, // R4
        {4'd3, 3'd7, 2'd1, 32'h1234ABCD, 3'd7, 2'd0, 32'h0000ABCD}, // R3
        {4'd2, 3'd3, 2'd2, 32'h0000005A, 3'd0, 2'd0, 32'h1122C377}, // R2
        {4'd6, 3'd2, 2'd0, 32'h80808080, 3'd2, 2'd3, 32'h00000080}  // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic do_write(input logic [2:0] idx, input logic [1:0] view, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_view = view; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every register reads zero after reset, on both ports
        for (int i = 0; i < 8; i++) begin
            rd0_idx = 3'(i); rd0_view = 2'd0;
            rd1_idx = 3'(7 - i); rd1_view = 2'd0;
            #1;
            check("R1 rd0", rd0_data, 32'h0);
            check("R1 rd1", rd1_data, 32'h0);
        end

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][73:71], VEC[v][70:69], VEC[v][68:37]);
            rd0_idx = VEC[v][36:34]; rd0_view = VEC[v][33:32];
            #1;
            check($sformatf("R%0d vec %0d", VEC[v][77:74], v), rd0_data, VEC[v][31:0]);
        end

        // R9: both ports at once on different registers and views
        rd0_idx = 3'd0; rd0_view = 2'd2;
        rd1_idx = 3'd1; rd1_view = 2'd0;
        #1;
        check("R9 rd0", rd0_data, 32'h00000077);
        check("R9 rd1", rd1_data, 32'hDEAD1234);
        rd0_idx = 3'd3; rd0_view = 2'd2;
        rd1_idx = 3'd3; rd1_view = 2'd3;
        #1;
        check("R9 rd0 same reg", rd0_data, 32'h0000005A);
        check("R9 rd1 same reg", rd1_data, 32'h00000000);

        // R7: illegal high-byte view on an upper register
        do_write(3'd4, 2'd0, 32'h01020304);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd4; wr_view = 2'd3; wr_data = 32'h000000FF;
        rd0_idx = 3'd4; rd0_view = 2'd3;
        rd1_idx = 3'd0; rd1_view = 2'd3;
        #1;
        check("R7 wr_err", 32'(wr_err), 32'd1);
        check("R7 rd0_err", 32'(rd0_err), 32'd1);
        check("R7 rd0_data", rd0_data, 32'h0);
        check("R7 rd1_err legal", 32'(rd1_err), 32'd0);
        check("R6 rd1 high byte", rd1_data, 32'h000000C3);
        @(negedge clk);
        wr_en = 1'b0;
        rd0_view = 2'd0;
        #1;
        check("R7 write dropped", rd0_data, 32'h01020304);
        check("R7 wr_err idle", 32'(wr_err), 32'd0);

        // R8: same-cycle read sees the old value
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd6; wr_view = 2'd0; wr_data = 32'h55AA55AA;
        rd0_idx = 3'd6; rd0_view = 2'd0;
        #1;
        check("R8 old value", rd0_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R8 new value", rd0_data, 32'h55AA55AA);

        // R10: write inputs active but strobe low
        @(negedge clk);
        wr_idx = 3'd0; wr_view = 2'd0; wr_data = 32'hFFFFFFFF;
        @(negedge clk);
        rd0_idx = 3'd0; rd0_view = 2'd0;
        #1;
        check("R10 no write", rd0_data, 32'h1122C377);

        // R1: reset in mid-run clears stored values
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd0_idx = 3'd0; rd1_idx = 3'd1; rd1_view = 2'd0;
        #1;
        check("R1 mid reset rd0", rd0_data, 32'h0);
        check("R1 mid reset rd1", rd1_data, 32'h0);

        summary();
    end

endmodule